// File: doc/BRIEF.md
# Cache Line Range Fill Engine

This block sits beside a last-level cache and carries out one zero or fill command over a contiguous run of cache lines. A command supplies a first line index, a number of lines and a full-line pattern. A pattern of all zeros gives a range zero. The engine does not signal each line to the issuer. It first sends a single invalidate message to the peer caches. That message carries the first index and the line count, so one message covers the whole range. The engine then waits until every peer has acknowledged.

Once every acknowledgement has arrived, the engine marks every line of the range as pending in one cycle. It then writes the pattern into the lines at one full line per clock. Each line leaves the pending state in the same edge that writes it.

Ordinary accesses reach the data array through a single access port. An access that names a pending line is stalled, and the stalled cycle has no effect. Accesses to lines that are not pending, including lines of the range that are already written, proceed at once. Later accesses are therefore ordered by the per-line pending state, and the issuer never has to wait for completion. The cache data array is modelled as an internal register array that clears to zero at reset. The number of lines must be a power of two, and line indices wrap modulo that number.

The controller is a state machine with six states:
- IDLE: waiting for a command.
- SEND: the invalidate message is presented for one cycle.
- WAIT: collecting acknowledgements.
- MARK: the whole range is set pending.
- FILL: one line is written per cycle.
- DONE: the one-cycle completion pulse.

It moves through these transitions:
- IDLE→SEND on an accepted command with a nonzero count.
- IDLE→DONE on an accepted command with a zero count.
- SEND→WAIT always.
- WAIT→MARK once every peer bit has been seen.
- MARK→FILL always.
- FILL→DONE on the last line.
- DONE→IDLE always.

Top module: `range_fill_engine`

## Requirements
- R1: After reset, cmd_busy, done, inv_valid and acc_stall are 0, and every line reads back as zero.
- R2: An accepted command with a nonzero count gives exactly one inv_valid cycle, in the cycle after acceptance. In that cycle inv_start equals the accepted first index and inv_count equals the accepted count.
- R3: Each bit of inv_ack is one peer's acknowledgement. Bits are remembered from the invalidate cycle onward, in any order and at any time. No line becomes pending, and done is not raised, until all N_PEERS bits have been seen.
- R4: All lines of the range become pending together, starting two cycles after the clock edge that samples the last missing acknowledgement. In the cycle before that, they are still accessible.
- R5: Lines are written in ascending index order from the first index, wrapping modulo NUM_LINES, one per clock. The first write is at the edge after the lines become pending. A written line reads back the pattern, with no stall, from the next cycle. done is high for exactly one cycle, immediately after the edge that writes the last line, and cmd_busy falls with it.
- R6: acc_stall is high exactly when acc_valid names a pending line. A stalled read gives no acc_rvalid, and a stalled write does not change the line.
- R7: A non-stalled write stores acc_wdata into line acc_idx. A non-stalled read returns the line on acc_rdata, with acc_rvalid high, in the cycle after the request.
- R8: cmd_accept is high in the cycle a command is taken, which is only when idle. cmd_busy is high from the next cycle up to and including the done cycle. A command offered while busy is not accepted and is never carried out.
- R9: An accepted command with a count of zero sends no invalidate message, raises done in the next cycle and changes no line.
- R10: Lines outside the commanded range keep their contents across a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_start | input | IDX_W | First line index of the range |
| cmd_count | input | CNT_W | Number of lines, 0 to NUM_LINES |
| cmd_pattern | input | LINE_W | Data written into every line of the range |
| cmd_accept | output | 1 | Command taken this cycle |
| cmd_busy | output | 1 | A command is in progress; new commands are refused |
| inv_valid | output | 1 | Range invalidate message to peer caches |
| inv_start | output | IDX_W | First line index carried by the message |
| inv_count | output | CNT_W | Line count carried by the message |
| inv_ack | input | N_PEERS | One acknowledgement bit per peer cache |
| acc_valid | input | 1 | Ordinary access request |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_idx | input | IDX_W | Line index of the access |
| acc_wdata | input | LINE_W | Write data |
| acc_stall | output | 1 | Access refused because its line is pending; retry later |
| acc_rdata | output | LINE_W | Read data |
| acc_rvalid | output | 1 | acc_rdata holds the result of the previous cycle's read |
| done | output | 1 | One-cycle pulse after the last line turns valid |

## Verification
The hardest situation to reach from the ports is the short window in which part of the range is written and valid while the rest is still pending. A second, related case is a stalled write that lands in that window and must leave its line untouched. The bench reaches both by timing its stimulus from the cycle in which it gives the last acknowledgement. It probes the first line as it turns valid, then the last line while it is still pending, and it drops a write onto a pending line. Acknowledgements arrive in a random order, with one peer sometimes held back for many cycles. Ranges include one that wraps past the top index, one that covers the whole array, and a zero-length one.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_MARK,
        ST_FILL,
        ST_DONE
    } rfe_state_t;

endpackage

// File: rtl/rfe_ack_gather.sv
module rfe_ack_gather #(
    parameter int N_PEERS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               enable,
    input  logic [N_PEERS-1:0] ack_in,
    output logic               all_seen
);

    logic [N_PEERS-1:0] seen_q;

    // One sticky flag per peer cache.
    for (genvar p = 0; p < N_PEERS; p++) begin : g_peer
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                seen_q[p] <= 1'b0;
            end else if (enable && ack_in[p]) begin
                seen_q[p] <= 1'b1;
            end
        end
    end

    assign all_seen = &seen_q;

endmodule

// File: rtl/rfe_ctrl.sv
module rfe_ctrl
    import rfe_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 9,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_start,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [LINE_W-1:0] cmd_pattern,
    input  logic              all_acked,
    output logic              cmd_accept,
    output logic              cmd_busy,
    output logic              inv_valid,
    output logic [IDX_W-1:0]  inv_start,
    output logic [CNT_W-1:0]  inv_count,
    output logic              ack_clear,
    output logic              ack_enable,
    output logic              mark_en,
    output logic [IDX_W-1:0]  mark_start,
    output logic [CNT_W-1:0]  mark_count,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [LINE_W-1:0] fill_data,
    output logic              done
);

    rfe_state_t        state_q, state_d;
    logic [IDX_W-1:0]  first_q;
    logic [CNT_W-1:0]  count_q;
    logic [LINE_W-1:0] pat_q;
    logic [IDX_W-1:0]  cur_q;
    logic [CNT_W-1:0]  left_q;
    logic              take;

    assign take = (state_q == ST_IDLE) && cmd_valid;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_d = (cmd_count == '0) ? ST_DONE : ST_SEND;
                end
            end
            ST_SEND: state_d = ST_WAIT;
            ST_WAIT: begin
                if (all_acked) begin
                    state_d = ST_MARK;
                end
            end
            ST_MARK: state_d = ST_FILL;
            ST_FILL: begin
                if (left_q == CNT_W'(1)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Command capture and fill walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            count_q <= '0;
            pat_q   <= '0;
            cur_q   <= '0;
            left_q  <= '0;
        end else begin
            if (take) begin
                first_q <= cmd_start;
                count_q <= cmd_count;
                pat_q   <= cmd_pattern;
            end
            if (state_q == ST_MARK) begin
                cur_q  <= first_q;
                left_q <= count_q;
            end else if (state_q == ST_FILL) begin
                cur_q  <= cur_q + IDX_W'(1);
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        cmd_accept = take;
        cmd_busy   = (state_q != ST_IDLE);
        inv_valid  = (state_q == ST_SEND);
        ack_clear  = take;
        ack_enable = (state_q == ST_SEND) || (state_q == ST_WAIT);
        mark_en    = (state_q == ST_MARK);
        fill_en    = (state_q == ST_FILL);
        done       = (state_q == ST_DONE);
        inv_start  = first_q;
        inv_count  = count_q;
        mark_start = first_q;
        mark_count = count_q;
        fill_idx   = cur_q;
        fill_data  = pat_q;
    end

endmodule

// File: rtl/rfe_line_store.sv
module rfe_line_store #(
    parameter int NUM_LINES = 256,
    parameter int LINE_W    = 64,
    parameter int IDX_W     = 8,
    parameter int CNT_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mark_en,
    input  logic [IDX_W-1:0]  mark_start,
    input  logic [CNT_W-1:0]  mark_count,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic [LINE_W-1:0] acc_wdata,
    output logic              acc_stall,
    output logic [LINE_W-1:0] acc_rdata,
    output logic              acc_rvalid
);

    logic [LINE_W-1:0]    line_q [NUM_LINES];
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] in_rng;
    logic                 go;

    // Per-line range membership: offset from the first index, modulo NUM_LINES.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_rng
        localparam logic [IDX_W-1:0] LINE_ID = IDX_W'(g);
        logic [IDX_W-1:0] off;
        assign off       = LINE_ID - mark_start;
        assign in_rng[g] = (CNT_W'(off) < mark_count);
    end

    assign acc_stall = acc_valid && pend_q[acc_idx];
    assign go        = acc_valid && !pend_q[acc_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (mark_en && in_rng[i]) begin
                    pend_q[i] <= 1'b1;
                end else if (fill_en && (fill_idx == IDX_W'(i))) begin
                    pend_q[i] <= 1'b0;
                end
            end
            if (go && acc_write) begin
                line_q[acc_idx] <= acc_wdata;
            end
            if (fill_en) begin
                line_q[fill_idx] <= fill_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid <= 1'b0;
            acc_rdata  <= '0;
        end else begin
            acc_rvalid <= go && !acc_write;
            if (go && !acc_write) begin
                acc_rdata <= line_q[acc_idx];
            end
        end
    end

endmodule

// File: rtl/range_fill_engine.sv
module range_fill_engine #(
    parameter int NUM_LINES = 256,
    parameter int LINE_W    = 64,
    parameter int N_PEERS   = 4,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int CNT_W    = $clog2(NUM_LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [IDX_W-1:0]   cmd_start,
    input  logic [CNT_W-1:0]   cmd_count,
    input  logic [LINE_W-1:0]  cmd_pattern,
    output logic               cmd_accept,
    output logic               cmd_busy,
    output logic               inv_valid,
    output logic [IDX_W-1:0]   inv_start,
    output logic [CNT_W-1:0]   inv_count,
    input  logic [N_PEERS-1:0] inv_ack,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic [LINE_W-1:0]  acc_wdata,
    output logic               acc_stall,
    output logic [LINE_W-1:0]  acc_rdata,
    output logic               acc_rvalid,
    output logic               done
);

    logic              all_acked;
    logic              ack_clear;
    logic              ack_enable;
    logic              mark_en;
    logic [IDX_W-1:0]  mark_start;
    logic [CNT_W-1:0]  mark_count;
    logic              fill_en;
    logic [IDX_W-1:0]  fill_idx;
    logic [LINE_W-1:0] fill_data;

    rfe_ctrl #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .LINE_W(LINE_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_start  (cmd_start),
        .cmd_count  (cmd_count),
        .cmd_pattern(cmd_pattern),
        .all_acked  (all_acked),
        .cmd_accept (cmd_accept),
        .cmd_busy   (cmd_busy),
        .inv_valid  (inv_valid),
        .inv_start  (inv_start),
        .inv_count  (inv_count),
        .ack_clear  (ack_clear),
        .ack_enable (ack_enable),
        .mark_en    (mark_en),
        .mark_start (mark_start),
        .mark_count (mark_count),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_data  (fill_data),
        .done       (done)
    );

    rfe_ack_gather #(
        .N_PEERS(N_PEERS)
    ) acks_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ack_clear),
        .enable  (ack_enable),
        .ack_in  (inv_ack),
        .all_seen(all_acked)
    );

    rfe_line_store #(
        .NUM_LINES(NUM_LINES),
        .LINE_W   (LINE_W),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_en   (mark_en),
        .mark_start(mark_start),
        .mark_count(mark_count),
        .fill_en   (fill_en),
        .fill_idx  (fill_idx),
        .fill_data (fill_data),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_idx   (acc_idx),
        .acc_wdata (acc_wdata),
        .acc_stall (acc_stall),
        .acc_rdata (acc_rdata),
        .acc_rvalid(acc_rvalid)
    );

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
    parameter int IDX_W   = 8,
    parameter int CNT_W   = 9,
    parameter int N_PEERS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [CNT_W-1:0]   cmd_count,
    input logic               cmd_accept,
    input logic               cmd_busy,
    input logic               inv_valid,
    input logic [CNT_W-1:0]   inv_count,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               acc_stall,
    input logic               acc_rvalid,
    input logic               done
);

    AST_INV_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && cmd_count != '0) |=> (inv_valid && inv_count == $past(cmd_count))); // R2

    AST_INV_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> !inv_valid); // R2

    AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |-> !cmd_accept); // R8

    AST_ACCEPT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> cmd_valid); // R8

    AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> (acc_valid && cmd_busy)); // R6

    AST_RVALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rvalid |-> $past(acc_valid && !acc_write && !acc_stall)); // R7

    AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && cmd_count == '0) |=> (done && !inv_valid)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !cmd_busy)); // R5

endmodule

bind range_fill_engine rfe_checker #(
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .N_PEERS(N_PEERS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_count (cmd_count),
    .cmd_accept(cmd_accept),
    .cmd_busy  (cmd_busy),
    .inv_valid (inv_valid),
    .inv_count (inv_count),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_stall (acc_stall),
    .acc_rvalid(acc_rvalid),
    .done      (done)
);

// File: tb/range_fill_engine_tb_top.sv
module range_fill_engine_tb_top;

    localparam int NUM_LINES = 256;
    localparam int LINE_W    = 64;
    localparam int N_PEERS   = 4;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int CNT_W     = $clog2(NUM_LINES + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic [IDX_W-1:0]   cmd_start = '0;
    logic [CNT_W-1:0]   cmd_count = '0;
    logic [LINE_W-1:0]  cmd_pattern = '0;
    logic               cmd_accept;
    logic               cmd_busy;
    logic               inv_valid;
    logic [IDX_W-1:0]   inv_start;
    logic [CNT_W-1:0]   inv_count;
    logic [N_PEERS-1:0] inv_ack = '0;
    logic               acc_valid = 1'b0;
    logic               acc_write = 1'b0;
    logic [IDX_W-1:0]   acc_idx = '0;
    logic [LINE_W-1:0]  acc_wdata = '0;
    logic               acc_stall;
    logic [LINE_W-1:0]  acc_rdata;
    logic               acc_rvalid;
    logic               done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [LINE_W-1:0] model [NUM_LINES];

    always #2 clk = ~clk;

    range_fill_engine #(
        .NUM_LINES(NUM_LINES),
        .LINE_W   (LINE_W),
        .N_PEERS  (N_PEERS)
    ) dut_i (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_eq(string req, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // True when line idx lies in the range [first, first+count) modulo NUM_LINES.
    function automatic bit in_range(int idx, int first, int count);
        int off;
        off = (idx - first + NUM_LINES) % NUM_LINES;
        return off < count;
    endfunction

    function automatic int last_line(int first, int count);
        return (first + count - 1) % NUM_LINES;
    endfunction

    task automatic read_line(string req, int idx);
        acc_valid = 1'b1;
        acc_write = 1'b0;
        acc_idx   = IDX_W'(idx);
        #1;
        check_eq(req, "read stall", acc_stall, 0);
        step();
        acc_valid = 1'b0;
        check_eq(req, "rvalid", acc_rvalid, 1);
        check_eq(req, $sformatf("line %0d", idx), acc_rdata, model[idx]);
    endtask

    task automatic write_line(int idx, logic [LINE_W-1:0] val);
        acc_valid = 1'b1;
        acc_write = 1'b1;
        acc_idx   = IDX_W'(idx);
        acc_wdata = val;
        #1;
        check_eq("R7", "write stall", acc_stall, 0);
        step();
        acc_valid = 1'b0;
        acc_write = 1'b0;
        model[idx] = val;
    endtask

    task automatic readback_all(string req);
        for (int i = 0; i < NUM_LINES; i++) begin
            read_line(req, i);
        end
    endtask

    task automatic do_cmd(int first, int count, logic [LINE_W-1:0] pat, int late_peer, bit try_refuse);
        int d [N_PEERS];
        int dmax;
        int lst;
        dmax = 0;
        lst  = last_line(first, count);
        for (int p = 0; p < N_PEERS; p++) begin
            d[p] = (p == late_peer) ? 12 : int'($urandom_range(0, 4));
            if (d[p] > dmax) dmax = d[p];
        end
        cmd_valid   = 1'b1;
        cmd_start   = IDX_W'(first);
        cmd_count   = CNT_W'(count);
        cmd_pattern = pat;
        #1;
        check_eq("R8", "accept when idle", cmd_accept, 1);
        step();
        cmd_valid = 1'b0;
        if (count == 0) begin
            #1;
            check_eq("R9", "done after zero count", done, 1);
            check_eq("R9", "no invalidate", inv_valid, 0);
            step();
            check_eq("R9", "done pulse ends", done, 0);
            check_eq("R9", "idle again", cmd_busy, 0);
            return;
        end
        #1;
        check_eq("R2", "inv_valid", inv_valid, 1);
        check_eq("R2", "inv_start", inv_start, LINE_W'(first));
        check_eq("R2", "inv_count", inv_count, LINE_W'(count));
        check_eq("R8", "busy after accept", cmd_busy, 1);
        // Acknowledgement window: lines must stay accessible.
        for (int t = 0; t <= dmax; t++) begin
            for (int p = 0; p < N_PEERS; p++) begin
                inv_ack[p] = (d[p] == t);
            end
            acc_valid = 1'b1;
            acc_write = 1'b0;
            acc_idx   = IDX_W'(first);
            if (t == 1 && try_refuse) begin
                cmd_valid   = 1'b1;
                cmd_start   = IDX_W'(first + 128);
                cmd_count   = CNT_W'(3);
                cmd_pattern = ~pat;
            end
            #1;
            check_eq("R3", "not pending before all acks", acc_stall, 0);
            check_eq("R3", "no done before all acks", done, 0);
            if (t > 0) check_eq("R2", "single invalidate cycle", inv_valid, 0);
            if (t == 1 && try_refuse) begin
                check_eq("R8", "refused while busy", cmd_accept, 0);
                check_eq("R8", "busy shown", cmd_busy, 1);
            end
            step();
            cmd_valid = 1'b0;
            inv_ack   = '0;
        end
        // One cycle after the last ack edge: still not pending.
        #1;
        check_eq("R4", "not pending one cycle after last ack", acc_stall, 0);
        step();
        #1;
        check_eq("R4", "not pending two edges after last ack", acc_stall, 0);
        step();
        // Lines now pending: a stalled write at the last line must have no effect.
        acc_valid = 1'b1;
        acc_write = 1'b1;
        acc_idx   = IDX_W'(lst);
        acc_wdata = ~pat;
        #1;
        check_eq("R4", "whole range pending", acc_stall, 1);
        step();
        for (int k = 1; k <= count; k++) begin
            acc_valid = 1'b1;
            acc_write = 1'b0;
            if (k == 1) begin
                acc_idx = IDX_W'(first);
                #1;
                check_eq("R5", "first line valid after its write", acc_stall, 0);
            end else begin
                acc_idx = IDX_W'(lst);
                #1;
                check_eq("R6", "last line stall", acc_stall, (k < count) ? 1 : 0);
                if (k == 2) begin
                    check_eq("R5", "first line rvalid", acc_rvalid, 1);
                    check_eq("R5", "first line data", acc_rdata, pat);
                end else begin
                    check_eq("R6", "no rvalid for stalled read", acc_rvalid, 0);
                end
            end
            check_eq("R5", "done timing", done, (k == count) ? 1 : 0);
            check_eq("R8", "busy until done", cmd_busy, 1);
            step();
        end
        acc_valid = 1'b0;
        #1;
        check_eq("R5", "done is one cycle", done, 0);
        check_eq("R8", "busy falls after done", cmd_busy, 0);
        for (int i = 0; i < count; i++) begin
            model[(first + i) % NUM_LINES] = pat;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_LINES; i++) model[i] = '0;
        repeat (5) step();
        rst_n = 1'b1;
        step();
        check_eq("R1", "busy after reset", cmd_busy, 0);
        check_eq("R1", "done after reset", done, 0);
        check_eq("R1", "inv_valid after reset", inv_valid, 0);
        readback_all("R1");

        // R7: plain writes while idle.
        for (int i = 0; i < 12; i++) begin
            write_line(int'($urandom_range(0, NUM_LINES - 1)), {$urandom, $urandom});
        end
        write_line(17, 64'h0123_4567_89ab_cdef);
        readback_all("R7");

        // Small range with neighbours set beforehand (R10).
        write_line(15, 64'h1515_1515_1515_1515);
        write_line(21, 64'h2121_2121_2121_2121);
        do_cmd(16, 5, 64'hdead_beef_cafe_f00d, -1, 1'b0);
        readback_all("R10");

        // Wrap past the top index, one late peer, refused command (R5 R3 R8).
        do_cmd(250, 10, 64'h5a5a_a5a5_0f0f_f0f0, 2, 1'b1);
        readback_all("R10");

        // Zero count (R9).
        do_cmd(40, 0, 64'hffff_ffff_ffff_ffff, -1, 1'b0);
        readback_all("R9");

        // Single line, then the whole array zeroed.
        do_cmd(255, 1, 64'h0000_0000_0000_0011, 0, 1'b0);
        readback_all("R10");
        do_cmd(0, NUM_LINES, 64'h0, -1, 1'b1);
        readback_all("R5");

        // Constrained random commands mixed with idle writes.
        for (int n = 0; n < 14; n++) begin
            int first;
            int count;
            int late;
            for (int w = 0; w < 4; w++) begin
                write_line(int'($urandom_range(0, NUM_LINES - 1)), {$urandom, $urandom});
            end
            first = int'($urandom_range(0, NUM_LINES - 1));
            count = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, NUM_LINES))
                                                : int'($urandom_range(0, 40));
            late  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, N_PEERS - 1)) : -1;
            do_cmd(first, count, {$urandom, $urandom}, late, 1'($urandom_range(0, 1)));
            readback_all("R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule